// File: doc/BRIEF.md
# Pipelined Correlated Double Sampler

This block removes the fixed offset of every pixel in a continuously read sensor sector. Raw ADC samples arrive one per clock, in raster order, with no gaps between frames. A frame memory holds the latest sample of every pixel. On every clock the block reads that stored value, subtracts it from the new sample, and writes the new sample back to the same location. The memory therefore always holds the most recent full frame.

The difference is clamped to an unsigned 8-bit range. It is then tagged with the pixel's row and column and marked valid. A one-bit-per-pixel hot mask can be written at any time. A masked pixel yields a zero value and a hot flag. The mask does not stop the frame memory from being updated.

The first frame after reset has no earlier sample to compare against, so it is flagged invalid. The sector geometry is set by parameters. A full sector is 640 rows by 320 columns, scanned at one sample per 20 ns clock. The default parameters are smaller, and the bench uses a 4 by 8 frame.

Top module: `pixel_cds_engine`

## Requirements
- R1: Output addresses follow the raster: the column runs fastest from 0 to COLS-1, then the row advances; after the last pixel of a frame the scan returns to row 0, column 0 with no idle cycle.
- R2: A sample taken at clock edge k appears on the outputs after edge k+1. One result is produced per clock, with no stall, and valid_o stays high on every cycle once it has risen.
- R3: When new minus stored lies in 0..255, pix_o equals that difference, where the stored value is the sample of the same pixel from the previous frame.
- R4: When new minus stored is negative, pix_o is 0.
- R5: When new minus stored exceeds 255, pix_o is 255.
- R6: The hot mask is addressed by the linear index row*COLS+col. It is written with mask_we_i, mask_idx_i and mask_hot_i, and a write takes effect for pixels scanned on later edges. A mask bit of 1 gives pix_o=0 with hot_o=1 and valid_o=1; a mask bit of 0 gives hot_o=0.
- R7: valid_o stays 0 for every pixel of the first frame after reset. The first valid result is row 0, column 0 of the second frame.
- R8: While rst_ni is low, valid_o, hot_o, pix_o, row_o and col_o are 0. Hot-mask contents survive a reset.
- R9: A pixel's sample is written back to the frame memory even while the pixel is masked. After unmasking, its difference is taken against that masked-period sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | RAW_W | Raw ADC sample of the current raster pixel |
| mask_we_i | input | 1 | Hot-mask write strobe |
| mask_idx_i | input | AW | Linear pixel index for the mask write |
| mask_hot_i | input | 1 | Mask bit to write (1 = hot) |
| pix_o | output | OUT_W | Clamped difference, or 0 for a hot pixel |
| hot_o | output | 1 | The pixel was suppressed by the mask |
| valid_o | output | 1 | The output carries a real difference |
| row_o | output | RW | Row of the output pixel |
| col_o | output | CW | Column of the output pixel |

## Verification
Each result is due on the outputs after the second rising edge after its sample is driven. The driver records the cycle count with each expected entry, and the monitor requires exactly two more cycles at the falling edge where it pops that entry. Mask writes are applied to the bench's model only after the pixel driven in the same cycle has been scored, which matches the read-before-write order of the mask. A valid result with nothing in the queue is scored as a first-frame violation. The bench also checks directly that the output is still invalid at the cycle just before the first valid result is due.

// File: rtl/cds_pkg.sv
package cds_pkg;
  function automatic int bits_for(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cds_raster.sv
module cds_raster #(
  parameter int ROWS = 32,
  parameter int COLS = 64,
  localparam int NPIX = ROWS * COLS,
  localparam int RW = cds_pkg::bits_for(ROWS),
  localparam int CW = cds_pkg::bits_for(COLS),
  localparam int AW = cds_pkg::bits_for(NPIX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic [AW-1:0] lin_o,
  output logic          primed_o
);
  logic row_end, col_end;

  assign col_end = (col_o == CW'(COLS - 1));
  assign row_end = (row_o == RW'(ROWS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o    <= '0;
      col_o    <= '0;
      lin_o    <= '0;
      primed_o <= 1'b0;
    end else if (col_end) begin
      col_o <= '0;
      if (row_end) begin
        row_o    <= '0;
        lin_o    <= '0;
        primed_o <= 1'b1;
      end else begin
        row_o <= row_o + 1'b1;
        lin_o <= lin_o + 1'b1;
      end
    end else begin
      col_o <= col_o + 1'b1;
      lin_o <= lin_o + 1'b1;
    end
  end
endmodule

// File: rtl/cds_frame_store.sv
// Read-first single-port RAM: the old word comes out the cycle after the address while the new word replaces it.
module cds_frame_store #(
  parameter int DEPTH = 2048,
  parameter int W     = 12,
  localparam int AW = cds_pkg::bits_for(DEPTH)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    rdata_o        <= mem_q[addr_i];
    mem_q[addr_i]  <= wdata_i;
  end
endmodule

// File: rtl/cds_hot_mask.sv
module cds_hot_mask #(
  parameter int DEPTH = 2048,
  localparam int AW = cds_pkg::bits_for(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] widx_i,
  input  logic          wbit_i,
  input  logic [AW-1:0] ridx_i,
  output logic          rbit_o
);
  logic mask_q [DEPTH];

  always_ff @(posedge clk_i) begin
    rbit_o <= mask_q[ridx_i];
    if (we_i) mask_q[widx_i] <= wbit_i;
  end
endmodule

// File: rtl/cds_diff.sv
module cds_diff #(
  parameter int RAW_W = 12,
  parameter int OUT_W = 8
) (
  input  logic [RAW_W-1:0] new_i,
  input  logic [RAW_W-1:0] old_i,
  output logic [OUT_W-1:0] diff_o
);
  localparam logic signed [RAW_W:0] CEIL = (RAW_W+1)'((1 << OUT_W) - 1);
  logic signed [RAW_W:0] delta;

  assign delta = $signed({1'b0, new_i}) - $signed({1'b0, old_i});

  always_comb begin
    if (delta < 0)         diff_o = '0;
    else if (delta > CEIL) diff_o = '1;
    else                   diff_o = delta[OUT_W-1:0];
  end
endmodule

// File: rtl/pixel_cds_engine.sv
module pixel_cds_engine #(
  parameter int ROWS  = 32,
  parameter int COLS  = 64,
  parameter int RAW_W = 12,
  parameter int OUT_W = 8,
  localparam int NPIX = ROWS * COLS,
  localparam int RW = cds_pkg::bits_for(ROWS),
  localparam int CW = cds_pkg::bits_for(COLS),
  localparam int AW = cds_pkg::bits_for(NPIX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RAW_W-1:0] sample_i,
  input  logic             mask_we_i,
  input  logic [AW-1:0]    mask_idx_i,
  input  logic             mask_hot_i,
  output logic [OUT_W-1:0] pix_o,
  output logic             hot_o,
  output logic             valid_o,
  output logic [RW-1:0]    row_o,
  output logic [CW-1:0]    col_o
);
  logic [RW-1:0]    scan_row;
  logic [CW-1:0]    scan_col;
  logic [AW-1:0]    scan_lin;
  logic             primed;
  logic [RAW_W-1:0] old_raw;
  logic             hot_bit;
  logic [OUT_W-1:0] diff;

  logic [RAW_W-1:0] s1_raw;
  logic [RW-1:0]    s1_row;
  logic [CW-1:0]    s1_col;
  logic             s1_live;

  cds_raster #(.ROWS(ROWS), .COLS(COLS)) raster_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .row_o    (scan_row),
    .col_o    (scan_col),
    .lin_o    (scan_lin),
    .primed_o (primed)
  );

  cds_frame_store #(.DEPTH(NPIX), .W(RAW_W)) store_i (
    .clk_i   (clk_i),
    .addr_i  (scan_lin),
    .wdata_i (sample_i),
    .rdata_o (old_raw)
  );

  cds_hot_mask #(.DEPTH(NPIX)) mask_i (
    .clk_i  (clk_i),
    .we_i   (mask_we_i),
    .widx_i (mask_idx_i),
    .wbit_i (mask_hot_i),
    .ridx_i (scan_lin),
    .rbit_o (hot_bit)
  );

  cds_diff #(.RAW_W(RAW_W), .OUT_W(OUT_W)) diff_i (
    .new_i  (s1_raw),
    .old_i  (old_raw),
    .diff_o (diff)
  );

  // stage 1: aligned with the memory read data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_raw  <= '0;
      s1_row  <= '0;
      s1_col  <= '0;
      s1_live <= 1'b0;
    end else begin
      s1_raw  <= sample_i;
      s1_row  <= scan_row;
      s1_col  <= scan_col;
      s1_live <= primed;
    end
  end

  // stage 2: registered result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      hot_o   <= 1'b0;
      valid_o <= 1'b0;
      row_o   <= '0;
      col_o   <= '0;
    end else begin
      pix_o   <= hot_bit ? '0 : diff;
      hot_o   <= s1_live & hot_bit;
      valid_o <= s1_live;
      row_o   <= s1_row;
      col_o   <= s1_col;
    end
  end
endmodule

// File: rtl/cds_checker.sv
module cds_checker #(
  parameter int ROWS  = 32,
  parameter int COLS  = 64,
  parameter int OUT_W = 8,
  localparam int RW = cds_pkg::bits_for(ROWS),
  localparam int CW = cds_pkg::bits_for(COLS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OUT_W-1:0] pix_o,
  input logic             hot_o,
  input logic             valid_o,
  input logic [RW-1:0]    row_o,
  input logic [CW-1:0]    col_o
);
  AST_HOT_IS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_o |-> (pix_o == '0) && valid_o); // R6

  AST_STREAM_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R2

  AST_FIRST_AT_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (row_o == '0) && (col_o == '0)); // R7

  AST_COL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |->
      (int'(col_o) == ((int'($past(col_o)) == COLS - 1) ? 0 : int'($past(col_o)) + 1))); // R1

  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && (int'($past(col_o)) != COLS - 1)) |->
      (row_o == $past(row_o))); // R1
endmodule

bind pixel_cds_engine cds_checker #(.ROWS(ROWS), .COLS(COLS), .OUT_W(OUT_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pix_o   (pix_o),
  .hot_o   (hot_o),
  .valid_o (valid_o),
  .row_o   (row_o),
  .col_o   (col_o)
);

// File: tb/pixel_cds_engine_tb_top.sv
module pixel_cds_engine_tb_top;
  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int NPIX = ROWS * COLS;
  localparam int RAW_W = 12;
  localparam int OUT_W = 8;
  localparam int AW = 5;
  localparam int RW = 2;
  localparam int CW = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [RAW_W-1:0] sample_i = '0;
  logic             mask_we_i = 1'b0;
  logic [AW-1:0]    mask_idx_i = '0;
  logic             mask_hot_i = 1'b0;
  logic [OUT_W-1:0] pix_o;
  logic             hot_o;
  logic             valid_o;
  logic [RW-1:0]    row_o;
  logic [CW-1:0]    col_o;

  pixel_cds_engine #(.ROWS(ROWS), .COLS(COLS), .RAW_W(RAW_W), .OUT_W(OUT_W)) dut_i (
    .clk_i, .rst_ni, .sample_i, .mask_we_i, .mask_idx_i, .mask_hot_i,
    .pix_o, .hot_o, .valid_o, .row_o, .col_o
  );

  always #10 clk_i = ~clk_i;

  typedef struct {
    int row; int col; int pix; int hot; int cyc; string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int prev_m[NPIX];
  bit mask_m[NPIX];
  int frame_m = 0;
  int kpix = 0;
  bit phase_b = 0;
  bit done = 0;

  always @(posedge clk_i) cyc++;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // driver: one sample per call, optional mask write in the same cycle
  task automatic drive(input int val, input bit wr = 0, input int idx = 0, input bit hv = 0);
    exp_t e;
    int d;
    @(negedge clk_i);
    if (kpix == 1 && frame_m == 1)
      check(valid_o == 1'b0, "R7", "valid before first compared pixel", int'(valid_o), 0);
    sample_i   = RAW_W'(val);
    mask_we_i  = wr;
    mask_idx_i = AW'(idx);
    mask_hot_i = hv;
    if (frame_m > 0) begin
      d = val - prev_m[kpix];
      e.row = kpix / COLS;
      e.col = kpix % COLS;
      e.hot = mask_m[kpix];
      e.cyc = cyc;
      if (e.hot) begin
        e.pix = 0;
        e.tag = phase_b ? "R8" : "R6";
      end else begin
        e.pix = (d < 0) ? 0 : ((d > 255) ? 255 : d);
        if (!phase_b && frame_m == 3 && kpix == 5) e.tag = "R9";
        else if (d < 0) e.tag = "R4";
        else if (d > 255) e.tag = "R5";
        else e.tag = "R3";
      end
      q.push_back(e);
    end
    prev_m[kpix] = val;
    if (wr) mask_m[idx] = hv;
    kpix++;
    if (kpix == NPIX) begin
      kpix = 0;
      frame_m++;
    end
  endtask

  function automatic int next_val(input int pat, input int k, input int p);
    int v;
    case (pat)
      1: v = p + (k * 37) % 256;
      2: v = p - (k % 9) * 11 - (k % 2);
      3: v = p + 256 + k * 20;
      4: v = 1000 + k;
      5: v = p + ((k % 4 == 0) ? 0 : (k % 4 == 1) ? 255 : (k % 4 == 2) ? 256 : 1);
      11: v = p + (k * 13) % 300;
      default: v = 400 + int'($urandom_range(2600));
    endcase
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic run_frame(input int pat);
    for (int k = 0; k < NPIX; k++) begin
      if (!phase_b && pat == 3 && k == 0)      drive(next_val(pat, k, prev_m[k]), 1, 5, 0);
      else if (!phase_b && pat == 3 && k == 1) drive(next_val(pat, k, prev_m[k]), 1, 20, 1);
      else                                     drive(next_val(pat, k, prev_m[k]));
    end
  endtask

  task automatic set_mask(input int idx, input bit hv);
    @(negedge clk_i);
    mask_we_i = 1'b1; mask_idx_i = AW'(idx); mask_hot_i = hv;
    mask_m[idx] = hv;
    @(negedge clk_i);
    mask_we_i = 1'b0;
  endtask

  task automatic check_reset_state();
    @(negedge clk_i);
    check(valid_o == 1'b0, "R8", "valid_o in reset", int'(valid_o), 0);
    check(hot_o == 1'b0, "R8", "hot_o in reset", int'(hot_o), 0);
    check(pix_o == '0, "R8", "pix_o in reset", int'(pix_o), 0);
    check(row_o == '0 && col_o == '0, "R8", "address in reset", int'(row_o) * COLS + int'(col_o), 0);
  endtask

  task automatic release_reset();
    @(posedge clk_i);
    #2 rst_ni = 1'b1;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R7", "valid output with nothing expected", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(int'(row_o) == e.row && int'(col_o) == e.col, "R1", "raster address",
              int'(row_o) * COLS + int'(col_o), e.row * COLS + e.col);
        check(cyc == e.cyc + 2, "R2", "result latency", cyc - e.cyc, 2);
        check(int'(pix_o) == e.pix, e.tag, "pixel value", int'(pix_o), e.pix);
        check(int'(hot_o) == e.hot, e.tag, "hot flag", int'(hot_o), e.hot);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NPIX; i++) begin
      set_mask(i, (i == 5 || i == 17) ? 1'b1 : 1'b0);
    end
    check_reset_state();
    release_reset();
    for (int f = 0; f < 6; f++) run_frame(f);

    // second run: reset mid-stream, mask must persist
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    q.delete();
    check_reset_state();
    phase_b = 1;
    frame_m = 0;
    kpix = 0;
    release_reset();
    run_frame(10);
    run_frame(11);

    wait (q.size() == 0);
    #1;
    done = 1;
    summary();
    $finish;
  end
endmodule